// File: doc/BRIEF.md
# Three-Stage Escalating Watchdog Timer

This block is a single-core watchdog that turns a missed keep-alive into a chain of increasingly severe responses. A 24-bit down-counter is stepped by a free-running prescaler. Software loads a 16-bit period value, which becomes the upper 16 bits of the counter, the lower 8 bits starting at zero. Each time the counter runs out without a keep-alive, the block moves one stage further. The first expiry raises an interrupt level. The second raises a non-maskable interrupt level. The third issues a one-cycle soft-reset request.

A two-bit mode selects how far the chain may go: off, interrupt only, interrupt plus NMI, or all three. Once the last enabled stage has fired, the counter parks at zero and the prescaler stops. A keep-alive strobe reloads the counter and clears the pending levels. A configuration write does the same with the new period and mode. The live count is always visible, so software can read how much time is left.

Top module: `staged_wdt`

## Requirements
- R1: A configuration write with a mode other than 0 loads the count with the period value shifted left by 8, so the low 8 bits are zero. The new count is visible one cycle after the write. A write with mode 0 loads zero.
- R2: While running, the count falls by exactly one once every 2^DIV_LOG2 clocks and holds between steps. The first step lands 2^DIV_LOG2 clocks after the restart. DIV_LOG2 defaults to 8 and is meant to be 8, 9 or 10 (a divisor of 256, 512 or 1024).
- R3: When the count runs out, which is (period<<8)·2^DIV_LOG2 clocks after a restart, the interrupt output goes high and the count reloads.
- R4: A second full period without a keep-alive raises the NMI output. The interrupt output stays high.
- R5: A third full period without a keep-alive gives a soft-reset request that lasts exactly one cycle. The count then stays at zero and both levels stay high.
- R6: Mode encoding: 0 means off; 1 fires the interrupt only; 2 fires the interrupt and the NMI; 3 fires all three stages. After the last enabled stage the timer stops with a count of zero.
- R7: A keep-alive strobe while enabled reloads the count from the stored period, clears the interrupt and NMI levels, and restarts at the first stage.
- R8: In mode 0 every output is low and the count is zero, and a keep-alive strobe changes nothing.
- R9: A period value of 0 makes every prescaler step an expiry, so the stages follow each other 2^DIV_LOG2 clocks apart.
- R10: A configuration write while the timer runs restarts the prescaler and the counter from the new period in that same cycle.
- R11: When a configuration write and a keep-alive strobe arrive in the same cycle, the configuration write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_len | input | 16 | Period value (upper counter bits) |
| cfg_mode | input | 2 | Escalation depth: 0 off, 1 irq, 2 irq+NMI, 3 all |
| kick | input | 1 | Keep-alive strobe |
| count_o | output | 24 | Live counter value |
| irq_o | output | 1 | Interrupt level |
| nmi_o | output | 1 | Non-maskable interrupt level |
| srst_o | output | 1 | One-cycle soft-reset request |

## Verification
A prescaler that steps at the wrong rate shows up within a few clocks of a restart, because the count then falls too early or too late. A stage register that is off by one shows at the first expiry, where the wrong output rises or the wrong output stays low. A counter that reloads or parks incorrectly shows one period later. At that point the count is not back at the period value, or it is not zero after the final stage. Keep-alive and configuration priority errors show in the cycle right after the strobe, through the count and the cleared levels.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        STG_WAIT_IRQ = 2'd0,
        STG_WAIT_NMI = 2'd1,
        STG_WAIT_RST = 2'd2,
        STG_DONE     = 2'd3
    } stage_e;

    typedef enum logic [1:0] {
        MODE_OFF     = 2'd0,
        MODE_IRQ     = 2'd1,
        MODE_IRQ_NMI = 2'd2,
        MODE_FULL    = 2'd3
    } mode_e;

    typedef struct packed {
        logic irq;
        logic nmi;
        logic srst;
    } alarm_t;

    function automatic stage_e next_stage(stage_e s);
        case (s)
            STG_WAIT_IRQ: return STG_WAIT_NMI;
            STG_WAIT_NMI: return STG_WAIT_RST;
            default:      return STG_DONE;
        endcase
    endfunction

    // True when the stage now expiring is the deepest one the mode allows.
    function automatic logic is_last_stage(stage_e s, mode_e m);
        return ({1'b0, s} + 3'd1) >= {1'b0, m};
    endfunction

endpackage

// File: rtl/wdt_cfg.sv
module wdt_cfg
    import wdt_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic [1:0]       cfg_mode,
    input  logic             kick,
    output mode_e            mode_q,
    output logic             restart,
    output logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] reload_val
);
    localparam int FRAC_W = CNT_W - LEN_W;

    logic [LEN_W-1:0] len_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q  <= '0;
            mode_q <= MODE_OFF;
        end else if (cfg_we) begin
            len_q  <= cfg_len;
            mode_q <= mode_e'(cfg_mode);
        end
    end

    // A config write always restarts; a kick only when enabled.
    assign restart    = cfg_we | (kick & (mode_q != MODE_OFF));
    assign reload_val = {len_q, {FRAC_W{1'b0}}};

    always_comb begin
        if (cfg_we)
            load_val = (cfg_mode == 2'd0) ? '0 : {cfg_len, {FRAC_W{1'b0}}};
        else
            load_val = reload_val;
    end

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int DIV_LOG2 = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    output logic tick
);
    localparam logic [DIV_LOG2-1:0] PRE_MAX = {DIV_LOG2{1'b1}};

    logic [DIV_LOG2-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (rst || restart)
            pre_q <= '0;
        else if (run)
            pre_q <= pre_q + DIV_LOG2'(1);
    end

    assign tick = run & ~restart & (pre_q == PRE_MAX);

    // R2
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/wdt_decrementer.sv
module wdt_decrementer #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             tick,
    input  logic             last,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    assign expire = tick & ~restart & (count <= CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (restart)
            count <= load_val;
        else if (expire)
            count <= last ? '0 : reload_val;
        else if (tick)
            count <= count - CNT_W'(1);
    end

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!restart && !tick) |=> $stable(count));

    // R1
    cnt_load_chk: assert property (@(posedge clk) disable iff (rst)
        (restart && !rst) |=> (count == $past(load_val)));

endmodule

// File: rtl/wdt_escalator.sv
module wdt_escalator
    import wdt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   restart,
    input  logic   expire,
    input  mode_e  mode_q,
    output stage_e stage_q,
    output logic   last,
    output alarm_t alarm
);
    assign last = is_last_stage(stage_q, mode_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= STG_WAIT_IRQ;
            alarm   <= '0;
        end else begin
            alarm.srst <= 1'b0;
            if (restart) begin
                stage_q   <= STG_WAIT_IRQ;
                alarm.irq <= 1'b0;
                alarm.nmi <= 1'b0;
            end else if (expire) begin
                case (stage_q)
                    STG_WAIT_IRQ: alarm.irq  <= 1'b1;
                    STG_WAIT_NMI: alarm.nmi  <= 1'b1;
                    STG_WAIT_RST: alarm.srst <= 1'b1;
                    default:      ;
                endcase
                stage_q <= last ? STG_DONE : next_stage(stage_q);
            end
        end
    end

    // R5
    srst_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        alarm.srst |=> !alarm.srst);

    // R4
    nmi_after_irq_chk: assert property (@(posedge clk) disable iff (rst)
        alarm.nmi |-> alarm.irq);

    // R8
    off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_OFF) |-> !(alarm.irq || alarm.nmi || alarm.srst));

    // R6
    irq_only_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_IRQ) |-> !(alarm.nmi || alarm.srst));

    // R7
    restart_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (restart && !rst) |=> (!alarm.irq && !alarm.nmi));

endmodule

// File: rtl/staged_wdt.sv
module staged_wdt
    import wdt_pkg::*;
#(
    parameter int LEN_W    = 16,
    parameter int CNT_W    = 24,
    parameter int DIV_LOG2 = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic [1:0]       cfg_mode,
    input  logic             kick,
    output logic [CNT_W-1:0] count_o,
    output logic             irq_o,
    output logic             nmi_o,
    output logic             srst_o
);
    mode_e            mode_q;
    stage_e           stage_q;
    alarm_t           alarm;
    logic             restart, tick, expire, last, run;
    logic [CNT_W-1:0] load_val, reload_val;

    wdt_cfg #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_cfg (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_len(cfg_len),
        .cfg_mode(cfg_mode), .kick(kick), .mode_q(mode_q),
        .restart(restart), .load_val(load_val), .reload_val(reload_val)
    );

    assign run = (mode_q != MODE_OFF) && (stage_q != STG_DONE);

    wdt_prescaler #(.DIV_LOG2(DIV_LOG2)) u_pre (
        .clk(clk), .rst(rst), .restart(restart), .run(run), .tick(tick)
    );

    wdt_decrementer #(.CNT_W(CNT_W)) u_dec (
        .clk(clk), .rst(rst), .restart(restart), .tick(tick), .last(last),
        .load_val(load_val), .reload_val(reload_val),
        .count(count_o), .expire(expire)
    );

    wdt_escalator u_esc (
        .clk(clk), .rst(rst), .restart(restart), .expire(expire),
        .mode_q(mode_q), .stage_q(stage_q), .last(last), .alarm(alarm)
    );

    assign irq_o  = alarm.irq;
    assign nmi_o  = alarm.nmi;
    assign srst_o = alarm.srst;

    // R5
    done_parked_chk: assert property (@(posedge clk) disable iff (rst)
        (stage_q == STG_DONE && !restart) |=> (count_o == '0));

endmodule

// File: tb/staged_wdt_bench.sv
module staged_wdt_bench;
    localparam int DIV_LOG2 = 2;
    localparam int DIV      = 1 << DIV_LOG2;
    localparam int P1       = 256 * DIV;

    typedef struct packed {
        logic [1:0]  mode;
        logic [15:0] len;
        logic        irq;
        logic        nmi;
        logic [1:0]  pulses;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{2'd1, 16'd1, 1'b1, 1'b0, 2'd0},
        '{2'd2, 16'd1, 1'b1, 1'b1, 2'd0},
        '{2'd3, 16'd1, 1'b1, 1'b1, 2'd1},
        '{2'd0, 16'd1, 1'b0, 1'b0, 2'd0},
        '{2'd3, 16'd0, 1'b1, 1'b1, 2'd1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_len = '0;
    logic [1:0]  cfg_mode = '0;
    logic        kick = 1'b0;
    logic [23:0] count_o;
    logic        irq_o, nmi_o, srst_o;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    staged_wdt #(.DIV_LOG2(DIV_LOG2)) u_staged_wdt (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_len(cfg_len),
        .cfg_mode(cfg_mode), .kick(kick), .count_o(count_o),
        .irq_o(irq_o), .nmi_o(nmi_o), .srst_o(srst_o)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg_write(input logic [1:0] m, input logic [15:0] l, input logic with_kick);
        cfg_we = 1'b1; cfg_mode = m; cfg_len = l; kick = with_kick;
        @(negedge clk);
        cfg_we = 1'b0; kick = 1'b0;
    endtask

    task automatic do_kick();
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog timeout");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int pulses;
        @(negedge clk);
        wait_edges(2);
        rst = 1'b0;
        wait_edges(1);
        chk("reset count", count_o, 0);
        chk("reset outputs", {irq_o, nmi_o, srst_o}, 0);

        // R1 / R2 / R3 / R4 / R5 full escalation, period 1
        cfg_write(2'd3, 16'd1, 1'b0);
        chk("R1 load", count_o, 256);
        wait_edges(DIV - 1);
        chk("R2 hold before step", count_o, 256);
        wait_edges(1);
        chk("R2 first step", count_o, 255);
        wait_edges(DIV);
        chk("R2 second step", count_o, 254);
        wait_edges(P1 - 1 - 2 * DIV);
        chk("R3 irq before expiry", irq_o, 0);
        wait_edges(1);
        chk("R3 irq at expiry", irq_o, 1);
        chk("R3 reload", count_o, 256);
        wait_edges(P1 - 1);
        chk("R4 nmi before", nmi_o, 0);
        wait_edges(1);
        chk("R4 nmi at expiry", nmi_o, 1);
        chk("R4 irq held", irq_o, 1);
        wait_edges(P1 - 1);
        chk("R5 srst before", srst_o, 0);
        wait_edges(1);
        chk("R5 srst pulse", srst_o, 1);
        wait_edges(1);
        chk("R5 srst single cycle", srst_o, 0);
        chk("R5 parked count", count_o, 0);
        wait_edges(50);
        chk("R5 still parked", count_o, 0);
        chk("R5 levels held", {irq_o, nmi_o}, 3);

        // R7 kick restarts
        do_kick();
        chk("R7 kick clears", {irq_o, nmi_o}, 0);
        chk("R7 kick reload", count_o, 256);
        wait_edges(P1 - 1);
        chk("R7 irq not yet", irq_o, 0);
        wait_edges(1);
        chk("R7 irq after period", irq_o, 1);

        // R10 reconfigure while running
        cfg_write(2'd3, 16'd2, 1'b0);
        chk("R10 load len2", count_o, 512);
        wait_edges(100);
        chk("R2 len2 progress", count_o, 512 - 100 / DIV);
        cfg_write(2'd3, 16'd1, 1'b0);
        chk("R10 reload new len", count_o, 256);
        wait_edges(P1 - 1);
        chk("R10 irq not yet", irq_o, 0);
        wait_edges(1);
        chk("R10 irq on new period", irq_o, 1);

        // R9 zero period
        cfg_write(2'd3, 16'd0, 1'b0);
        chk("R9 count zero", count_o, 0);
        wait_edges(DIV - 1);
        chk("R9 irq before", irq_o, 0);
        wait_edges(1);
        chk("R9 irq", irq_o, 1);
        wait_edges(DIV);
        chk("R9 nmi", nmi_o, 1);
        wait_edges(DIV);
        chk("R9 srst", srst_o, 1);

        // R8 disabled
        cfg_write(2'd0, 16'd5, 1'b0);
        chk("R8 off count", count_o, 0);
        chk("R8 off outputs", {irq_o, nmi_o, srst_o}, 0);
        do_kick();
        chk("R8 kick ignored", count_o, 0);
        wait_edges(2000);
        chk("R8 stays quiet", {irq_o, nmi_o, srst_o}, 0);
        chk("R8 count still zero", count_o, 0);

        // R11 config beats kick
        cfg_write(2'd3, 16'd1, 1'b0);
        cfg_write(2'd0, 16'd7, 1'b1);
        chk("R11 off wins over kick", count_o, 0);
        cfg_write(2'd3, 16'd2, 1'b1);
        chk("R11 new len wins over kick", count_o, 512);

        // R6 mode table
        foreach (VECS[i]) begin
            cfg_write(VECS[i].mode, VECS[i].len, 1'b0);
            pulses = 0;
            for (int c = 0; c < 3 * P1 + 20; c++) begin
                wait_edges(1);
                if (srst_o) pulses++;
            end
            chk($sformatf("R6 vec%0d irq", i), irq_o, VECS[i].irq);
            chk($sformatf("R6 vec%0d nmi", i), nmi_o, VECS[i].nmi);
            chk($sformatf("R6 vec%0d srst pulses", i), pulses, VECS[i].pulses);
            chk($sformatf("R6 vec%0d idle count", i), count_o, 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule